// File: doc/BRIEF.md
# I2C Status Byte and Interrupt Flag Unit

This block holds the eight-bit read-only status byte of an I2C bus interface and drives the interrupt line of that interface. The bus engine reports what happens on the wire through single-cycle strobes: own address matched, general call seen, byte finished, stop seen, and acknowledge slot with the sampled acknowledge bit. It also reports level conditions: arbitration lost, bus busy, transmitting and slave role. The block combines these with the acknowledge-enable and general-call-enable configuration bits. From them it decides when to raise the interrupt flag and which status flags to set or clear.

The interface counts as the selected slave from a qualified address or general-call match until the next stop condition. A byte that completes in master mode always raises the interrupt, even when arbitration was lost during it. A byte that completes in slave mode raises it only while the interface is selected. A stop condition raises it only while the interface is selected. A mode-suppress input blocks the interrupt flag from being set, and all other status bits keep updating. When software reads the status byte through the read strobe, the interrupt flag clears. If a new interrupt is raised in the same cycle, the new interrupt wins.

Top module: `i2c_stat_irq`

## Requirements
- R1: While reset is held (rst_n = 0), stat_o is 8'h00 and irq_o is 0.
- R2: The status bits are, from bit 7 down to bit 0: general call, stop, interrupt, transmit, busy, lost, nack, slave. Bits 4, 3, 2 and 0 show tx_mode_i, bus_busy_i, arb_lost_i and slave_mode_i as sampled at the previous rising edge.
- R3: An addr_match_i strobe with ack_en_i = 1 sets the interrupt bit (bit 5) at the next edge. With ack_en_i = 0 the strobe leaves bit 5 and the selection unchanged.
- R4: A gcall_i strobe with both gc_en_i = 1 and ack_en_i = 1 sets bit 5 and the general-call bit (bit 7) together. If either enable is 0, the strobe has no effect.
- R5: A byte_done_i strobe while slave_mode_i = 0 sets bit 5, whatever the state of arb_lost_i.
- R6: A byte_done_i strobe while slave_mode_i = 1 sets bit 5 only if the interface is selected. A qualified addr_match_i or gcall_i selects the interface. Any stop_det_i strobe deselects it.
- R7: A stop_det_i strobe while the interface is selected sets bit 5 and the stop bit (bit 6). A stop_det_i strobe while the interface is not selected changes neither bit.
- R8: An ack_slot_i strobe loads bit 1 with ack_bit_i (1 = NACK received, 0 = ACK received). Without the strobe, bit 1 holds.
- R9: While suppress_i = 1, no event sets bit 5. Bits 7, 6 and 1 and the selection still update.
- R10: A stat_rd_i pulse clears bit 5 at the next edge. If a set event falls in the same cycle, the set wins. The byte returned during the read cycle is the value from before the update.
- R11: irq_o always equals bit 5 of stat_o.
- R12: A qualified addr_match_i clears bits 7 and 6. A qualified gcall_i clears bit 6. If the stop bit is set in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_match_i | input | 1 | Strobe: own slave address received |
| gcall_i | input | 1 | Strobe: general-call address received |
| byte_done_i | input | 1 | Strobe: data byte sent or received |
| stop_det_i | input | 1 | Strobe: stop condition seen |
| ack_slot_i | input | 1 | Strobe: acknowledge slot completed |
| ack_bit_i | input | 1 | Acknowledge bit sampled at the slot (1 = NACK) |
| arb_lost_i | input | 1 | Level: arbitration lost |
| bus_busy_i | input | 1 | Level: bus held by another master |
| tx_mode_i | input | 1 | Level: interface is transmitting |
| slave_mode_i | input | 1 | Level: interface is in the slave role |
| ack_en_i | input | 1 | Configuration: acknowledge enable |
| gc_en_i | input | 1 | Configuration: general-call enable |
| suppress_i | input | 1 | Blocks interrupt setting |
| stat_rd_i | input | 1 | CPU read strobe for the status byte |
| stat_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a slave byte or stop event that depends on the selection state. The selection state is not visible at any port. It exists only as the history of earlier address matches and stops. The stimulus therefore runs directed sequences that select, then deselect, and then repeat byte and stop strobes in both states. A read pulse lands in the same cycle as a set event, and suppress_i toggles while the interface stays selected. A long weighted random phase then mixes every strobe and level, and a behavioural model checks every bit on every clock.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
   localparam int STAT_W   = 8;
   localparam int B_GC     = 7;
   localparam int B_STOP   = 6;
   localparam int B_INT    = 5;
   localparam int B_TX     = 4;
   localparam int B_BUSY   = 3;
   localparam int B_LOST   = 2;
   localparam int B_NACK   = 1;
   localparam int B_SLAVE  = 0;
   localparam int LVL_W    = 4;

   typedef struct packed {
      logic tx;
      logic busy;
      logic lost;
      logic slave;
   } lvl_t;

   typedef struct packed {
      logic set_int;
      logic set_gc;
      logic clr_gc;
      logic set_stop;
      logic clr_stop;
   } evt_t;
endpackage

// File: rtl/i2c_stat_lvl_sync.sv
module i2c_stat_lvl_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
      initial $fatal(1, "i2c_stat_lvl_sync: STAGES must be 1..4");
   end

   if (STAGES == 1) begin : g_single
      logic [WIDTH-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= '0;
         else        r <= d_i;
      end
      assign q_o = r;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= '0;
         else        r <= {r[STAGES-2:0], d_i};
      end
      assign q_o = r[STAGES-1];

      // R2
      chain_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $stable(r[0]) |=> r[1] == $past(r[0]));
   end
endmodule

// File: rtl/i2c_stat_evt_qual.sv
module i2c_stat_evt_qual
   import i2c_stat_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic addr_match_i,
   input  logic gcall_i,
   input  logic byte_done_i,
   input  logic stop_det_i,
   input  logic slave_mode_i,
   input  logic ack_en_i,
   input  logic gc_en_i,
   input  logic suppress_i,
   output evt_t evt_o
);
   logic sel_q;
   logic q_addr, q_gc, q_stop, q_byte;

   always_comb begin
      q_addr = addr_match_i & ack_en_i;
      q_gc   = gcall_i & gc_en_i & ack_en_i;
      q_stop = stop_det_i & sel_q;
      q_byte = byte_done_i & (~slave_mode_i | sel_q);
      evt_o.set_int  = (q_addr | q_gc | q_stop | q_byte) & ~suppress_i;
      evt_o.set_gc   = q_gc;
      evt_o.clr_gc   = q_addr;
      evt_o.set_stop = q_stop;
      evt_o.clr_stop = q_addr | q_gc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               sel_q <= 1'b0;
      else if (q_addr | q_gc)   sel_q <= 1'b1;
      else if (stop_det_i)      sel_q <= 1'b0;
   end

   // R7
   sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det_i && !addr_match_i && !gcall_i) |=> !sel_q);

   // R6
   sel_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_match_i && ack_en_i) |=> sel_q);
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
   import i2c_stat_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  evt_t evt_i,
   input  logic ack_slot_i,
   input  logic ack_bit_i,
   input  logic stat_rd_i,
   input  logic suppress_i,
   output logic int_o,
   output logic gc_o,
   output logic stop_o,
   output logic nack_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_o  <= 1'b0;
         gc_o   <= 1'b0;
         stop_o <= 1'b0;
         nack_o <= 1'b0;
      end else begin
         if (evt_i.set_int)       int_o <= 1'b1;
         else if (stat_rd_i)      int_o <= 1'b0;

         if (evt_i.set_gc)        gc_o <= 1'b1;
         else if (evt_i.clr_gc)   gc_o <= 1'b0;

         if (evt_i.set_stop)      stop_o <= 1'b1;
         else if (evt_i.clr_stop) stop_o <= 1'b0;

         if (ack_slot_i)          nack_o <= ack_bit_i;
      end
   end

   // R10
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_i && !evt_i.set_int) |=> !int_o);

   // R9
   suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (suppress_i && !int_o) |=> !int_o);

   // R8
   nack_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_slot_i |=> nack_o == $past(ack_bit_i));

   // R8
   nack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_slot_i |=> $stable(nack_o));
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq
   import i2c_stat_pkg::*;
#(
   parameter int SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_match_i,
   input  logic              gcall_i,
   input  logic              byte_done_i,
   input  logic              stop_det_i,
   input  logic              ack_slot_i,
   input  logic              ack_bit_i,
   input  logic              arb_lost_i,
   input  logic              bus_busy_i,
   input  logic              tx_mode_i,
   input  logic              slave_mode_i,
   input  logic              ack_en_i,
   input  logic              gc_en_i,
   input  logic              suppress_i,
   input  logic              stat_rd_i,
   output logic [STAT_W-1:0] stat_o,
   output logic              irq_o
);
   lvl_t lvl_d, lvl_q;
   evt_t evt;
   logic f_int, f_gc, f_stop, f_nack;

   assign lvl_d = '{tx: tx_mode_i, busy: bus_busy_i, lost: arb_lost_i, slave: slave_mode_i};

   i2c_stat_lvl_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STAGES)) u_lvl (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (lvl_d),
      .q_o   (lvl_q)
   );

   i2c_stat_evt_qual u_qual (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr_match_i (addr_match_i),
      .gcall_i      (gcall_i),
      .byte_done_i  (byte_done_i),
      .stop_det_i   (stop_det_i),
      .slave_mode_i (slave_mode_i),
      .ack_en_i     (ack_en_i),
      .gc_en_i      (gc_en_i),
      .suppress_i   (suppress_i),
      .evt_o        (evt)
   );

   i2c_stat_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .ack_slot_i (ack_slot_i),
      .ack_bit_i  (ack_bit_i),
      .stat_rd_i  (stat_rd_i),
      .suppress_i (suppress_i),
      .int_o      (f_int),
      .gc_o       (f_gc),
      .stop_o     (f_stop),
      .nack_o     (f_nack)
   );

   always_comb begin
      stat_o          = '0;
      stat_o[B_GC]    = f_gc;
      stat_o[B_STOP]  = f_stop;
      stat_o[B_INT]   = f_int;
      stat_o[B_TX]    = lvl_q.tx;
      stat_o[B_BUSY]  = lvl_q.busy;
      stat_o[B_LOST]  = lvl_q.lost;
      stat_o[B_NACK]  = f_nack;
      stat_o[B_SLAVE] = lvl_q.slave;
   end

   assign irq_o = f_int;

   // R3
   int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_match_i && ack_en_i && !suppress_i) |=> irq_o);

   // R4
   gc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gcall_i && gc_en_i && ack_en_i) |=> stat_o[B_GC]);

   if (SYNC_STAGES == 1) begin : g_mirror_chk
      // R2
      busy_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> stat_o[B_BUSY] == $past(bus_busy_i));
   end
endmodule

// File: tb/i2c_stat_irq_test.sv
`timescale 1ns/100ps
module i2c_stat_irq_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_match_i = 0, gcall_i = 0, byte_done_i = 0, stop_det_i = 0;
   logic ack_slot_i = 0, ack_bit_i = 0, arb_lost_i = 0, bus_busy_i = 0;
   logic tx_mode_i = 0, slave_mode_i = 0, ack_en_i = 0, gc_en_i = 0;
   logic suppress_i = 0, stat_rd_i = 0;
   logic [7:0] stat_o;
   logic irq_o;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   i2c_stat_irq uut (
      .clk(clk), .rst_n(rst_n),
      .addr_match_i(addr_match_i), .gcall_i(gcall_i), .byte_done_i(byte_done_i),
      .stop_det_i(stop_det_i), .ack_slot_i(ack_slot_i), .ack_bit_i(ack_bit_i),
      .arb_lost_i(arb_lost_i), .bus_busy_i(bus_busy_i), .tx_mode_i(tx_mode_i),
      .slave_mode_i(slave_mode_i), .ack_en_i(ack_en_i), .gc_en_i(gc_en_i),
      .suppress_i(suppress_i), .stat_rd_i(stat_rd_i),
      .stat_o(stat_o), .irq_o(irq_o)
   );

   // behavioural reference: one integer per status bit, plus selection memory
   int m_bit [8];
   int m_chosen = 0;

   initial for (int i = 0; i < 8; i++) m_bit[i] = 0;

   always @(posedge clk) begin
      int own, gen, stp, byt, raise;
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) m_bit[i] = 0;
         m_chosen = 0;
      end else begin
         own   = (addr_match_i && ack_en_i) ? 1 : 0;
         gen   = (gcall_i && gc_en_i && ack_en_i) ? 1 : 0;
         stp   = (stop_det_i && m_chosen != 0) ? 1 : 0;
         byt   = (byte_done_i && (!slave_mode_i || m_chosen != 0)) ? 1 : 0;
         raise = ((own + gen + stp + byt) > 0 && !suppress_i) ? 1 : 0;
         if (raise != 0) m_bit[5] = 1;
         else if (stat_rd_i) m_bit[5] = 0;
         if (gen != 0) m_bit[7] = 1;
         else if (own != 0) m_bit[7] = 0;
         if (stp != 0) m_bit[6] = 1;
         else if (own + gen > 0) m_bit[6] = 0;
         if (ack_slot_i) m_bit[1] = ack_bit_i;
         if (own + gen > 0) m_chosen = 1;
         else if (stop_det_i) m_chosen = 0;
         m_bit[4] = tx_mode_i;
         m_bit[3] = bus_busy_i;
         m_bit[2] = arb_lost_i;
         m_bit[0] = slave_mode_i;
      end
   end

   function automatic string tag_of(int b);
      case (b)
         7: return "R4/R12 gc bit";
         6: return "R7/R12 stop bit";
         5: return "R3/R5/R6/R9/R10 int bit";
         1: return "R8 nack bit";
         default: return "R2 level bit";
      endcase
   endfunction

   always @(negedge clk) begin
      if (!finished) begin
         if (!rst_n) begin
            checks++;
            if (stat_o !== 8'h00 || irq_o !== 1'b0) begin
               errors++;
               $display("FAIL R1 reset: stat=%h irq=%b expected 00 0", stat_o, irq_o);
            end
         end else begin
            for (int b = 0; b < 8; b++) begin
               checks++;
               if (stat_o[b] !== m_bit[b][0]) begin
                  errors++;
                  $display("FAIL %s [%0d] at %0t: actual=%b expected=%0d",
                           tag_of(b), b, $time, stat_o[b], m_bit[b]);
               end
            end
            checks++;
            if (irq_o !== stat_o[5]) begin
               errors++;
               $display("FAIL R11 irq: actual=%b expected=%b", irq_o, stat_o[5]);
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
      addr_match_i = 0; gcall_i = 0; byte_done_i = 0; stop_det_i = 0;
      ack_slot_i = 0; stat_rd_i = 0;
   endtask

   task automatic rd();
      stat_rd_i = 1; tick();
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R3 unqualified then qualified address match
      ack_en_i = 0; addr_match_i = 1; tick();
      slave_mode_i = 1; byte_done_i = 1; tick();   // R6 not selected
      ack_en_i = 1; addr_match_i = 1; tick();
      rd();
      byte_done_i = 1; tick();                    // R6 selected
      rd();
      // R10 read and set in same cycle
      byte_done_i = 1; stat_rd_i = 1; tick();
      rd(); tick();
      // R9 suppress while selected
      suppress_i = 1; byte_done_i = 1; tick();
      ack_slot_i = 1; ack_bit_i = 1; tick();       // R8
      suppress_i = 0;
      stop_det_i = 1; tick();                     // R7 selected stop
      rd();
      stop_det_i = 1; tick();                     // R7 unselected stop
      byte_done_i = 1; tick();                    // R6 after deselect
      // R4 general call variants
      gc_en_i = 0; gcall_i = 1; tick();
      gc_en_i = 1; ack_en_i = 0; gcall_i = 1; tick();
      ack_en_i = 1; gcall_i = 1; tick();
      rd();
      // R12 own address clears gc and stop
      stop_det_i = 1; tick();
      addr_match_i = 1; tick();
      // R5 master byte with arbitration lost
      rd(); slave_mode_i = 0; arb_lost_i = 1; byte_done_i = 1; tick();
      rd(); arb_lost_i = 0; bus_busy_i = 1; tx_mode_i = 1; tick();
      ack_slot_i = 1; ack_bit_i = 0; tick();
      // random phase across all inputs
      for (int n = 0; n < 4000; n++) begin
         addr_match_i = ($urandom_range(0, 7) == 0);
         gcall_i      = ($urandom_range(0, 9) == 0);
         byte_done_i  = ($urandom_range(0, 3) == 0);
         stop_det_i   = ($urandom_range(0, 7) == 0);
         ack_slot_i   = ($urandom_range(0, 3) == 0);
         ack_bit_i    = $urandom_range(0, 1);
         stat_rd_i    = ($urandom_range(0, 2) == 0);
         if ($urandom_range(0, 15) == 0) begin
            arb_lost_i   = $urandom_range(0, 1);
            bus_busy_i   = $urandom_range(0, 1);
            tx_mode_i    = $urandom_range(0, 1);
            slave_mode_i = $urandom_range(0, 1);
            ack_en_i     = ($urandom_range(0, 3) != 0);
            gc_en_i      = $urandom_range(0, 1);
            suppress_i   = ($urandom_range(0, 5) == 0);
         end
         tick();
      end
      tick(); tick();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         finished = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule